// File: doc/BRIEF.md
# Banked Output-Enable Controller

This block decides, for every pad of a logic block, whether its three-state buffer drives the pin. The pads are split into banks of eight. Each bank receives its own pair of shared enable terms from the product-term logic. Each pad has a two-bit buffer mode and a one-bit term select. A pad can be held off, held on, or made to follow one of the two terms of its own bank. A pad never follows a term from another bank.

Enables and pad data are registered. The pins therefore follow the macrocell outputs one clock later, with a matching enable. An observe input turns on every buffer at once, so that register contents become visible on the pins during test. Each pin also returns a feedback value. A pad whose buffer is off reports its external level, so it can act as an input.

Top module: `io_oe_ctl`

## Requirements
- R1: While rst_n is low, every pad_oe_o bit and every pad_out_o bit is 0.
- R2: A pad whose mode field (cell_mode_i bits 2i+1:2i for pad i) is 2'b00 has its enable low one cycle later, unless observe_i is high.
- R3: A pad whose mode field is 2'b01 has its enable high one cycle later.
- R4: A pad in mode 2'b10 takes, one cycle later, the enable term chosen by its select bit term_sel_i[i]. Pads 0 to 7 use oe_term_i[0] (select 0) or oe_term_i[1] (select 1). Pads 8 to 15 use oe_term_i[2] (select 0) or oe_term_i[3] (select 1).
- R5: Mode 2'b11 is reserved and behaves as disabled: enable low one cycle later, unless observe_i is high.
- R6: The enable terms of one bank have no effect on the enables of pads in the other bank.
- R7: When observe_i is high, every enable is high one cycle later, whatever the modes, selects and terms.
- R8: pad_out_o equals mc_data_i from the previous cycle.
- R9: io_fb_o[i] equals pad_out_o[i] while pad_oe_o[i] is high, and pad_in_i[i] otherwise, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, applied synchronously |
| observe_i | input | 1 | Forces all buffers on |
| oe_term_i | input | 4 | Shared enable terms, two per bank, bank 0 in the low bits |
| cell_mode_i | input | 32 | Two-bit buffer mode per pad |
| term_sel_i | input | 16 | Term select per pad |
| mc_data_i | input | 16 | Macrocell output data |
| pad_in_i | input | 16 | External pin level |
| pad_out_o | output | 16 | Registered pad data |
| pad_oe_o | output | 16 | Registered buffer enables |
| io_fb_o | output | 16 | Pin feedback value |

## Verification
The hardest behaviour to reach is bank isolation. It shows only when term-controlled pads in one bank hold still while the other bank's terms toggle underneath them. Random stimulus seldom produces this with a clean bank split. Directed steps therefore place bank 0 in term mode with fixed selects and walk the bank 1 terms through every value, and then do the same with the banks swapped. A walking-one pattern on the four terms, with alternating selects, shows that each pad picks the correct term.

// File: rtl/oe_ctl_pkg.sv
package oe_ctl_pkg;

   typedef enum logic [1:0] {
      OE_OFF  = 2'b00,
      OE_ON   = 2'b01,
      OE_TERM = 2'b10,
      OE_RSVD = 2'b11
   } oe_mode_e;

   // Buffer enable for one pad before any override is applied.
   function automatic logic oe_decode(input oe_mode_e mode, input logic term);
      logic en;
      case (mode)
         OE_ON:   en = 1'b1;
         OE_TERM: en = term;
         default: en = 1'b0;
      endcase
      return en;
   endfunction

endpackage

// File: rtl/oe_cell_mux.sv
module oe_cell_mux
   import oe_ctl_pkg::*;
#(
   parameter int TERMS = 2,
   parameter int SEL_W = 1
) (
   input  logic [1:0]       mode_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic [TERMS-1:0] terms_i,
   input  logic             force_i,
   output logic             en_o
);

   logic picked;

   always_comb begin
      picked = 1'b0;
      for (int t = 0; t < TERMS; t++) begin
         if (int'(sel_i) == t) picked = terms_i[t];
      end
   end

   assign en_o = force_i | oe_decode(oe_mode_e'(mode_i), picked);

endmodule

// File: rtl/oe_bank.sv
module oe_bank #(
   parameter int CELLS = 8,
   parameter int TERMS = 2,
   parameter int SEL_W = 1
) (
   input  logic [2*CELLS-1:0]     mode_i,
   input  logic [CELLS*SEL_W-1:0] sel_i,
   input  logic [TERMS-1:0]       terms_i,
   input  logic                   force_i,
   output logic [CELLS-1:0]       en_o
);

   for (genvar c = 0; c < CELLS; c++) begin : g_cell
      oe_cell_mux #(.TERMS(TERMS), .SEL_W(SEL_W)) u_mux (
         .mode_i  (mode_i[2*c +: 2]),
         .sel_i   (sel_i[c*SEL_W +: SEL_W]),
         .terms_i (terms_i),
         .force_i (force_i),
         .en_o    (en_o[c])
      );
   end

endmodule

// File: rtl/oe_out_stage.sv
module oe_out_stage #(
   parameter int WIDTH      = 16,
   parameter bit REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] en_d,
   input  logic [WIDTH-1:0] data_d,
   output logic [WIDTH-1:0] en_q,
   output logic [WIDTH-1:0] data_q
);

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_q   <= '0;
            data_q <= '0;
         end else begin
            en_q   <= en_d;
            data_q <= data_d;
         end
      end
   end else begin : g_comb
      assign en_q   = rst_n ? en_d   : '0;
      assign data_q = rst_n ? data_d : '0;
      logic unused_clk;
      assign unused_clk = clk;
   end

endmodule

// File: rtl/io_oe_ctl.sv
module io_oe_ctl #(
   parameter int NUM_CELLS  = 16,
   parameter int BANK_CELLS = 8,
   parameter int BANK_TERMS = 2,
   parameter bit OUT_REG    = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  observe_i,
   input  logic [3:0]            oe_term_i,
   input  logic [31:0]           cell_mode_i,
   input  logic [15:0]           term_sel_i,
   input  logic [15:0]           mc_data_i,
   input  logic [15:0]           pad_in_i,
   output logic [15:0]           pad_out_o,
   output logic [15:0]           pad_oe_o,
   output logic [15:0]           io_fb_o
);

   localparam int NUM_BANKS = NUM_CELLS / BANK_CELLS;
   localparam int SEL_W     = (BANK_TERMS > 1) ? $clog2(BANK_TERMS) : 1;

   if (NUM_CELLS % BANK_CELLS != 0) begin : g_bad_split
      $error("NUM_CELLS must be a multiple of BANK_CELLS");
   end
   if (NUM_BANKS * BANK_TERMS != 4 || NUM_CELLS != 16 || SEL_W != 1) begin : g_bad_ports
      $error("parameters do not match the port widths");
   end

   logic [NUM_CELLS-1:0] en_d;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      oe_bank #(.CELLS(BANK_CELLS), .TERMS(BANK_TERMS), .SEL_W(SEL_W)) u_bank (
         .mode_i  (cell_mode_i[2*b*BANK_CELLS +: 2*BANK_CELLS]),
         .sel_i   (term_sel_i[b*BANK_CELLS*SEL_W +: BANK_CELLS*SEL_W]),
         .terms_i (oe_term_i[b*BANK_TERMS +: BANK_TERMS]),
         .force_i (observe_i),
         .en_o    (en_d[b*BANK_CELLS +: BANK_CELLS])
      );
   end

   oe_out_stage #(.WIDTH(NUM_CELLS), .REGISTERED(OUT_REG)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_d   (en_d),
      .data_d (mc_data_i),
      .en_q   (pad_oe_o),
      .data_q (pad_out_o)
   );

   assign io_fb_o = (pad_oe_o & pad_out_o) | (~pad_oe_o & pad_in_i);

   if (OUT_REG) begin : g_chk
      // R7
      observe_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
         observe_i |=> (&pad_oe_o));
      // R8
      data_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rst_n |=> (pad_out_o == $past(mc_data_i)));
      for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell_chk
         // R2 R5
         off_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!observe_i && (cell_mode_i[2*i +: 2] == 2'b00 || cell_mode_i[2*i +: 2] == 2'b11))
            |=> !pad_oe_o[i]);
         // R3
         on_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cell_mode_i[2*i +: 2] == 2'b01) |=> pad_oe_o[i]);
         // R4 R6
         term_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!observe_i && cell_mode_i[2*i +: 2] == 2'b10)
            |=> (pad_oe_o[i] == $past(oe_term_i[(i/BANK_CELLS)*BANK_TERMS + int'(term_sel_i[i])])));
      end
   end

endmodule

// File: tb/sim_io_oe_ctl.sv
module sim_io_oe_ctl;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        observe_i;
   logic [3:0]  oe_term_i;
   logic [31:0] cell_mode_i;
   logic [15:0] term_sel_i;
   logic [15:0] mc_data_i;
   logic [15:0] pad_in_i;
   logic [15:0] pad_out_o;
   logic [15:0] pad_oe_o;
   logic [15:0] io_fb_o;

   int checks   = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   io_oe_ctl u0 (
      .clk(clk), .rst_n(rst_n), .observe_i(observe_i), .oe_term_i(oe_term_i),
      .cell_mode_i(cell_mode_i), .term_sel_i(term_sel_i), .mc_data_i(mc_data_i),
      .pad_in_i(pad_in_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o), .io_fb_o(io_fb_o)
   );

   // Expected enables from the requirements (R2 R3 R4 R5 R7).
   function automatic logic [15:0] exp_oe(input logic obs, input logic [31:0] modes,
                                          input logic [15:0] sel, input logic [3:0] terms);
      logic [15:0] e;
      for (int i = 0; i < 16; i++) begin
         case (modes[2*i +: 2])
            2'b01:   e[i] = 1'b1;
            2'b10:   e[i] = terms[(i/8)*2 + int'(sel[i])];
            default: e[i] = 1'b0;
         endcase
         if (obs) e[i] = 1'b1;
      end
      return e;
   endfunction

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Called at a falling edge: drive, cross one rising edge, check.
   task automatic step(input logic obs, input logic [31:0] modes, input logic [15:0] sel,
                       input logic [3:0] terms, input logic [15:0] data, input string req);
      logic [15:0] e;
      observe_i   = obs;
      cell_mode_i = modes;
      term_sel_i  = sel;
      oe_term_i   = terms;
      mc_data_i   = data;
      e = exp_oe(obs, modes, sel, terms);
      @(negedge clk);
      chk(pad_oe_o == e, req, 32'(pad_oe_o), 32'(e));
      chk(pad_out_o == data, "R8", 32'(pad_out_o), 32'(data));
   endtask

   task automatic fb_check(input logic [15:0] pin);
      logic [15:0] e;
      pad_in_i = pin;
      #1;
      e = (pad_oe_o & pad_out_o) | (~pad_oe_o & pin);
      chk(io_fb_o == e, "R9", 32'(io_fb_o), 32'(e));
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n       = 1'b0;
      observe_i   = 1'b1;
      cell_mode_i = {16{2'b01}};
      term_sel_i  = '1;
      oe_term_i   = '1;
      mc_data_i   = 16'hFFFF;
      pad_in_i    = 16'h0000;
      repeat (3) @(negedge clk);
      // R1
      chk(pad_oe_o == 16'h0, "R1", 32'(pad_oe_o), 32'h0);
      chk(pad_out_o == 16'h0, "R1", 32'(pad_out_o), 32'h0);
      rst_n = 1'b1;

      // R2 all disabled
      step(1'b0, {16{2'b00}}, 16'h0, 4'hF, 16'hA5A5, "R2");
      fb_check(16'h3C3C);
      // R3 all enabled
      step(1'b0, {16{2'b01}}, 16'h0, 4'h0, 16'h5A5A, "R3");
      fb_check(16'hFFFF);
      // R5 reserved mode
      step(1'b0, {16{2'b11}}, 16'hFFFF, 4'hF, 16'h1234, "R5");
      fb_check(16'hC3C3);
      // R4 walking one over the terms, alternating selects
      for (int t = 0; t < 4; t++) begin
         step(1'b0, {16{2'b10}}, 16'hAAAA, 4'(1 << t), 16'h0F0F, "R4");
         step(1'b0, {16{2'b10}}, 16'h5555, 4'(1 << t), 16'hF0F0, "R4");
         fb_check(16'h6666);
      end
      // R6 bank 0 in term mode, bank 1 terms toggle underneath
      for (int t = 0; t < 4; t++) begin
         step(1'b0, {{8{2'b00}}, {8{2'b10}}}, 16'h00F0, {2'(t), 2'b01}, 16'h00FF, "R6");
      end
      // R6 bank 1 in term mode, bank 0 terms toggle underneath
      for (int t = 0; t < 4; t++) begin
         step(1'b0, {{8{2'b10}}, {8{2'b00}}}, 16'h0F00, {2'b10, 2'(t)}, 16'hFF00, "R6");
      end
      // R7 observe overrides disabled and reserved pads
      step(1'b1, {{8{2'b00}}, {8{2'b11}}}, 16'h0, 4'h0, 16'hBEEF, "R7");
      fb_check(16'h0000);
      step(1'b1, {16{2'b10}}, 16'hFFFF, 4'h0, 16'hCAFE, "R7");

      // Random mix, including observe
      for (int n = 0; n < 400; n++) begin
         step(($urandom % 8) == 0, $urandom, 16'($urandom), 4'($urandom), 16'($urandom), "R4/R7 random");
         fb_check(16'($urandom));
      end

      // R1 reset applied again mid-run
      rst_n = 1'b0;
      @(negedge clk);
      chk(pad_oe_o == 16'h0, "R1", 32'(pad_oe_o), 32'h0);
      chk(pad_out_o == 16'h0, "R1", 32'(pad_out_o), 32'h0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule